// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire bus decoder in a byte-addressed nonvolatile memory model. The decoder hands it a word address at the start of a write transaction, then one strobe per received data byte, then a strobe when the transaction ends with a stop. The block gathers the bytes into a page-sized holding buffer. Only the low offset bits of the address advance, so a long burst wraps back to the start of the same page and overwrites what it put there earlier. A per-byte written mask records which lanes hold new data.

When the stop arrives and at least one byte was gathered, the buffered lanes are committed to the array through a self-timed write cycle. The length of that cycle is a parameter counted in system clock cycles. While it runs the block reports busy. The decoder's device-select attempts get no acknowledge, and every address load, data strobe and stop is dropped. The first select after the cycle ends is acknowledged, so a host can poll for completion. A high write-protect level turns the commit into a discard. A stop that ends a transaction with no data bytes, such as the address-setting phase of a random read, starts no cycle. A registered read port gives access to the array at all times.

Top module: `page_write_commit`

## Requirements
- R1: The page holds 8 bytes (3 offset bits) when ARRAY_BYTES is 256 and 16 bytes (4 offset bits) when it is 512; the offset is the low bits of the byte address and the page number is the remaining upper bits.
- R2: An address load while idle latches the page number and the starting offset from `load_addr` and clears the written mask; it takes priority over a data strobe in the same cycle.
- R3: Each accepted data byte is placed at the current offset of the latched page, after which only the offset increments, modulo the page size; the page number never changes during the burst.
- R4: When more bytes than one page are sent, the offset wraps to offset 0 of the same page and the last byte sent to an offset is the one committed.
- R5: A commit changes only the array bytes whose lanes were written since the last address load; all other bytes of the page keep their old values.
- R6: A stop while idle, with `wp` low and at least one byte gathered, raises `busy` from the next cycle for exactly WRITE_CYCLES cycles; the array holds the new bytes from the cycle in which `busy` falls.
- R7: `dev_ack` in a cycle is high exactly when `dev_sel` was high in the previous cycle and `busy` was low then.
- R8: While `busy` is high, address loads, data strobes and stops have no effect on the buffer, the array or the cycle length, and no second cycle follows.
- R9: A stop with `wp` high starts no cycle, leaves the array unchanged and discards the gathered bytes.
- R10: A stop with no data byte gathered since the last address load starts no cycle.
- R11: `rd_data` shows the array byte at the `rd_addr` of the previous cycle, whatever the level of `wp`.
- R12: After reset `busy` and `dev_ack` are low and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp | input | 1 | Write protect; high turns commits into discards |
| addr_load | input | 1 | Strobe: latch the start address of a write |
| load_addr | input | log2(ARRAY_BYTES) | Start byte address |
| byte_valid | input | 1 | Strobe: one data byte received |
| byte_data | input | 8 | Received data byte |
| stop | input | 1 | Strobe: the transaction ended with a stop |
| dev_sel | input | 1 | Strobe: a matching device address was received |
| dev_ack | output | 1 | Acknowledge for the device address of the previous cycle |
| busy | output | 1 | Self-timed write cycle in progress |
| rd_addr | input | log2(ARRAY_BYTES) | Read byte address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with ARRAY_BYTES = 512, which gives 16-byte pages. With 16-byte pages, a 20-byte burst that starts near the end of a page crosses the wrap point and lands its last bytes on lanes it wrote earlier. WRITE_CYCLES is cut to 24 so that the exact cycle length can be counted. The shorter cycle also leaves room to poll for the acknowledge and to inject address, data and stop strobes in the middle of a cycle. The 8-byte page of the 256-byte variant follows from the same offset arithmetic but is reached only through the parameter.

// File: rtl/pwb_pkg.sv
// Package pwb_pkg
// Shared sizing helpers for the page write buffer. Assumes the array is
// either 256 or 512 bytes; larger arrays use the wide page size.
package pwb_pkg;

    localparam int BYTE_W = 8;

    // Page size in bytes selected from the array size.
    function automatic int page_bytes_of(input int array_bytes);
        return (array_bytes > 256) ? 16 : 8;
    endfunction

endpackage

// File: rtl/pwb_page_buf.sv
// Module pwb_page_buf
// Holds one page of incoming write data with a per-lane written mask.
// The latched page number never changes during a burst; only the offset
// counter advances and wraps within the page. Assumes the caller gates
// every strobe with accept_en while a write cycle runs.
module pwb_page_buf #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PSEL_W    = ADDR_W - OFS_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                accept_en,
    input  logic                                addr_load,
    input  logic [ADDR_W-1:0]                   load_addr,
    input  logic                                byte_valid,
    input  logic [pwb_pkg::BYTE_W-1:0]          byte_data,
    input  logic                                clear,
    output logic [PSEL_W-1:0]                   page_sel,
    output logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] page_data,
    output logic [PAGE_BYTES-1:0]               wr_mask
);

    logic [OFS_W-1:0] ofs_q;
    logic             do_load;
    logic             do_byte;

    // Qualify strobes: a load wins over a byte in the same cycle.
    always_comb begin
        do_load = accept_en && addr_load;
        do_byte = accept_en && byte_valid && !addr_load;
    end

    // Page number register, loaded only by an accepted address load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_sel <= '0;
        end else if (do_load) begin
            page_sel <= load_addr[ADDR_W-1:OFS_W];
        end
    end

    // Offset counter: loaded from the low address bits, wraps on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (do_load) begin
            ofs_q <= load_addr[OFS_W-1:0];
        end else if (do_byte) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic hit;

        // Lane select for the current offset.
        always_comb hit = do_byte && (ofs_q == OFS_W'(g));

        // Lane data: last byte written to this offset is kept.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_data[g] <= '0;
            end else if (hit) begin
                page_data[g] <= byte_data;
            end
        end

        // Lane written flag: cleared by a new address or by commit/discard.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_mask[g] <= 1'b0;
            end else if (clear || do_load) begin
                wr_mask[g] <= 1'b0;
            end else if (hit) begin
                wr_mask[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwb_commit_timer.sv
// Module pwb_commit_timer
// Self-timed write cycle. A start pulse raises busy for exactly
// WRITE_CYCLES clock cycles; fire marks the last of them, when the
// array takes the page. Assumes start is only pulsed while idle.
module pwb_commit_timer #(
    parameter int WRITE_CYCLES = 625000,
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);

    logic [CNT_W-1:0] remain_q;

    // Last busy cycle: the commit takes effect at its closing edge.
    always_comb fire = busy && (remain_q == '0);

    // Cycle counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                remain_q <= CNT_W'(WRITE_CYCLES - 1);
            end
        end else if (fire) begin
            busy <= 1'b0;
        end else begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/pwb_array.sv
// Module pwb_array
// Byte array with a masked whole-page write port and a registered read
// port. Reset fills it with 8'hFF, the erased value. Assumes page_sel,
// page_data and wr_mask are stable while we is high.
module pwb_array #(
    parameter int ARRAY_BYTES = 512,
    parameter int PAGE_BYTES  = 16,
    localparam int ADDR_W     = $clog2(ARRAY_BYTES),
    localparam int OFS_W      = $clog2(PAGE_BYTES),
    localparam int PSEL_W     = ADDR_W - OFS_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [PSEL_W-1:0]                   page_sel,
    input  logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]               wr_mask,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [pwb_pkg::BYTE_W-1:0]          rd_data
);

    logic [pwb_pkg::BYTE_W-1:0] mem [ARRAY_BYTES];

    // Storage: erase on reset, masked page write on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARRAY_BYTES; a++) begin
                mem[a] <= '1;
            end
        end else if (we) begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (wr_mask[l]) begin
                    mem[{page_sel, OFS_W'(l)}] <= page_data[l];
                end
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '1;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/page_write_commit.sv
// Module page_write_commit
// Page write buffer with a timed commit into the byte array. Receives
// decoded bus events (address load, data byte, stop, device select) and
// owns the busy window during which all of them are ignored. Assumes the
// bus decoder issues at most one strobe kind per cycle.
module page_write_commit #(
    parameter int ARRAY_BYTES  = 512,
    parameter int WRITE_CYCLES = 625000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wp,
    input  logic                         addr_load,
    input  logic [$clog2(ARRAY_BYTES)-1:0] load_addr,
    input  logic                         byte_valid,
    input  logic [7:0]                   byte_data,
    input  logic                         stop,
    input  logic                         dev_sel,
    output logic                         dev_ack,
    output logic                         busy,
    input  logic [$clog2(ARRAY_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data
);

    localparam int ADDR_W     = $clog2(ARRAY_BYTES);
    localparam int PAGE_BYTES = pwb_pkg::page_bytes_of(ARRAY_BYTES);
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    localparam int PSEL_W     = ADDR_W - OFS_W;

    logic [PSEL_W-1:0]                   page_sel;
    logic [PAGE_BYTES-1:0][7:0]          page_data;
    logic [PAGE_BYTES-1:0]               wr_mask;
    logic                                stop_ok;
    logic                                start_cycle;
    logic                                discard;
    logic                                fire;

    // Stop decisions: commit gathered bytes, or discard under protect.
    always_comb begin
        stop_ok     = stop && !busy;
        start_cycle = stop_ok && !wp && (|wr_mask);
        discard     = stop_ok && wp;
    end

    pwb_page_buf #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_en  (!busy),
        .addr_load  (addr_load),
        .load_addr  (load_addr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .clear      (fire || discard),
        .page_sel   (page_sel),
        .page_data  (page_data),
        .wr_mask    (wr_mask)
    );

    pwb_commit_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_cycle),
        .busy  (busy),
        .fire  (fire)
    );

    pwb_array #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (fire),
        .page_sel  (page_sel),
        .page_data (page_data),
        .wr_mask   (wr_mask),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // Device address acknowledge, withheld for the whole write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_ack <= 1'b0;
        end else begin
            dev_ack <= dev_sel && !busy;
        end
    end

endmodule

// File: rtl/pwb_checker.sv
// Module pwb_checker
// Temporal checks on the page write buffer, bound into page_write_commit.
// The busy window length is measured with a local counter.
module pwb_checker #(
    parameter int WRITE_CYCLES = 24,
    parameter int PAGE_BYTES   = 16,
    parameter int PSEL_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp,
    input logic              addr_load,
    input logic              byte_valid,
    input logic              stop,
    input logic              dev_ack,
    input logic              busy,
    input logic [PSEL_W-1:0] page_sel,
    input logic [PAGE_BYTES-1:0] wr_mask
);

    logic [31:0] run_q;

    // Count cycles spent busy so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    // R7
    busy_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dev_ack);

    // R6
    commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && !wp && (|wr_mask)) |=> busy);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 32'(WRITE_CYCLES)));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == 32'(WRITE_CYCLES - 1)));

    // R9
    wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && wp) |=> !busy);

    // R10
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && (wr_mask == '0)) |=> !busy);

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !addr_load) |=> $stable(page_sel));

    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_sel));

endmodule

bind page_write_commit pwb_checker #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .PAGE_BYTES   (PAGE_BYTES),
    .PSEL_W       (PSEL_W)
) u_pwb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp         (wp),
    .addr_load  (addr_load),
    .byte_valid (byte_valid),
    .stop       (stop),
    .dev_ack    (dev_ack),
    .busy       (busy),
    .page_sel   (page_sel),
    .wr_mask    (wr_mask)
);

// File: tb/page_write_commit_bench.sv
// Directed bench for page_write_commit: one task per scenario, each
// comparing the ports against a byte model of the array.
module page_write_commit_bench;

    localparam int ARRAY_BYTES = 512;
    localparam int WCYC        = 24;
    localparam int AW          = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop = 1'b0;
    logic          dev_sel = 1'b0;
    logic          dev_ack;
    logic          busy;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [ARRAY_BYTES];

    always #4 clk = ~clk;

    page_write_commit #(
        .ARRAY_BYTES  (ARRAY_BYTES),
        .WRITE_CYCLES (WCYC)
    ) u_page_write_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp         (wp),
        .addr_load  (addr_load),
        .load_addr  (load_addr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .stop       (stop),
        .dev_sel    (dev_sel),
        .dev_ack    (dev_ack),
        .busy       (busy),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input int a);
        addr_load = 1'b1; load_addr = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic do_byte(input int d);
        byte_valid = 1'b1; byte_data = 8'(d);
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = AW'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic chk_mem(input string req, input int a);
        int v;
        rd(a, v);
        chk(req, v, int'(model[a]));
    endtask

    // Wait out a write cycle, polling early and optionally injecting strobes.
    task automatic wait_cycle(input bit inject, output int n);
        n = 0;
        while (busy) begin
            n++;
            dev_sel = (n == 1);
            if (n == 2) chk("R7 ack withheld while busy", int'(dev_ack), 0);
            if (inject) begin
                addr_load  = (n == 3); load_addr = AW'(9'h180);
                byte_valid = (n == 4); byte_data = 8'h77;
                stop       = (n == 5);
            end
            @(negedge clk);
        end
        dev_sel = 1'b0; addr_load = 1'b0; byte_valid = 1'b0; stop = 1'b0;
        dev_sel = 1'b1;
        @(negedge clk);
        dev_sel = 1'b0;
        chk("R7 ack after cycle ends", int'(dev_ack), 1);
    endtask

    task automatic t_reset();
        chk("R12 busy after reset", int'(busy), 0);
        chk("R12 ack after reset", int'(dev_ack), 0);
        chk_mem("R12 erased byte 0", 0);
        chk_mem("R12 erased last byte", ARRAY_BYTES - 1);
    endtask

    task automatic t_partial();
        int n;
        do_load(9'h023);                       // R2 page 2, offset 3
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        model[9'h023] = 8'h11; model[9'h024] = 8'h22; model[9'h025] = 8'h33;
        do_stop();
        chk("R6 busy rises after stop", int'(busy), 1);
        wait_cycle(1'b0, n);
        chk("R6 cycle length", n, WCYC);
        chk_mem("R5 untouched below", 9'h022);
        chk_mem("R2 first byte at start offset", 9'h023);
        chk_mem("R3 next offset", 9'h024);
        chk_mem("R3 third offset", 9'h025);
        chk_mem("R5 untouched above", 9'h026);
        chk_mem("R5 untouched page base", 9'h020);
    endtask

    task automatic t_wrap();
        int n;
        do_load(9'h04E);
        for (int k = 0; k < 20; k++) begin
            do_byte(8'hA0 + k);
            model[9'h040 + ((14 + k) % 16)] = 8'(8'hA0 + k);
        end
        do_stop();
        wait_cycle(1'b0, n);
        chk("R6 cycle length on wrap", n, WCYC);
        for (int o = 0; o < 16; o++) chk_mem("R4 R1 wrapped lane", 9'h040 + o);
        chk_mem("R3 next page untouched", 9'h050);
        chk_mem("R3 previous page untouched", 9'h03F);
    endtask

    task automatic t_protect();
        int v;
        wp = 1'b1;
        do_load(9'h080);
        do_byte(8'h5C); do_byte(8'h6D);
        do_stop();
        chk("R9 no cycle under protect", int'(busy), 0);
        chk_mem("R9 protected byte unchanged", 9'h080);
        chk_mem("R11 read under protect", 9'h023);
        wp = 1'b0;
        do_stop();                             // R9 buffer was discarded
        chk("R9 discarded data not committed", int'(busy), 0);
        rd(9'h081, v);
        chk("R9 second lane unchanged", v, int'(model[9'h081]));
    endtask

    task automatic t_empty();
        do_load(9'h0C7);
        do_stop();
        chk("R10 no cycle without data", int'(busy), 0);
        @(negedge clk);
        chk("R10 still idle", int'(busy), 0);
    endtask

    task automatic t_ignore();
        int n;
        do_load(9'h100);
        do_byte(8'h5A);
        model[9'h100] = 8'h5A;
        do_stop();
        wait_cycle(1'b1, n);
        chk("R8 cycle length with injected strobes", n, WCYC);
        @(negedge clk);
        chk("R8 no second cycle", int'(busy), 0);
        chk_mem("R8 committed byte intact", 9'h100);
        chk_mem("R8 ignored byte not stored", 9'h101);
        chk_mem("R8 ignored address not used", 9'h180);
        do_stop();
        chk("R8 ignored data left nothing to commit", int'(busy), 0);
    endtask

    initial begin
        for (int a = 0; a < ARRAY_BYTES; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial();
        t_wrap();
        t_protect();
        t_empty();
        t_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule